// File: doc/BRIEF.md
# Dual-Output Waveform Timer Channel

This block is a single timer channel that produces two pulse-width modulated outputs, A and B, from one shared up-counter. The counter steps on a tick from a selectable prescaler. It returns to zero when it equals the period compare value. Each output has its own duty compare value. For every event that can touch an output, the output carries a 2-bit action: none, set, clear or toggle. The events are its own duty match, the period match and a software trigger. Set on the period match and clear on the duty match gives a normal PWM waveform. Swapping those two actions gives the inverted waveform.

Software programs the channel through a plain register-write port. The writable registers are a mode word (clock select plus the six actions), two duty compare values, a period value and a command register. The command register holds start, stop and trigger bits. A trigger zeroes the counter and the prescaler, loads the pending compare values and applies each output's trigger action. Leave all compare actions at none and the trigger level stays on the output indefinitely, which gives 0% or 100% duty. Compare and period writes go to holding registers and take effect at the next period wrap or trigger, so the running cycle keeps its timing.

Top module: `wtc_channel`

## Requirements
- R1: After reset the counter value is 0, both outputs are 0 and the channel is stopped.
- R2: While running, the counter advances by one on each tick and goes to 0 on the tick where it equals the active period value P, so it visits 0..P.
- R3: Mode bits [4:3], [6:5] and [8:7] hold output A's action for the A duty match, the period match and the trigger. Bits [10:9], [12:11] and [14:13] hold the same for output B. Encoding: 0 none, 1 set, 2 clear, 3 toggle. With set-on-period and clear-on-match, output A is high for D+1 of every P+1 counter steps, where D is the duty value.
- R4: With the actions reversed (set on match, clear on period), output B is high for P-D of every P+1 counter steps.
- R5: Both outputs share the one period value and have the same repetition period.
- R6: A toggle action inverts the output on each occurrence of its event. A none action leaves the output unchanged.
- R7: When the duty match and the period match occur on the same tick, the period action wins over the duty action.
- R8: With no compare actions programmed, each output holds the level set by its trigger action indefinitely, which gives 0% and 100% duty.
- R9: The command register is address 4 with bit 0 start, bit 1 stop and bit 2 trigger. Stop wins when start and stop are written together. While stopped, the counter and both outputs hold their values.
- R10: Writes to the duty registers (addresses 1, 2) and the period register (address 3) are held pending. They become active at the next period wrap or trigger, so the running cycle finishes with the old values.
- R11: Mode bits [2:0] select the tick. Codes 0, 1, 2 and 3 divide the main clock by 2, 8, 32 and 128. Codes 4 and above use one tick per pulse on slow_tick.
- R12: A trigger zeroes the counter and prescaler at the next edge and overrides any compare action on that edge.
- R13: A trigger written together with stop applies the trigger levels and leaves the channel stopped with those levels held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe, one write per cycle |
| cfg_addr | input | 3 | Register address: 0 mode, 1 duty A, 2 duty B, 3 period, 4 command |
| cfg_wdata | input | CNT_W | Write data |
| slow_tick | input | 1 | One-cycle pulse from the slow time base, synchronous to clk |
| out_a | output | 1 | Waveform output A |
| out_b | output | 1 | Waveform output B |
| count | output | CNT_W | Current counter value |

## Verification
The assertions assume that slow_tick is a single-cycle pulse synchronous to clk. They also assume that a command write never shares a cycle with a mode write, which the single address bus already guarantees. The period-range property relies on the counter only ever reaching the active period through a wrap or a trigger. The stimulus therefore programs duty values no larger than the period and issues every configuration change through the write port one register per cycle. Slow-clock pulses are driven isolated, with idle cycles between them.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TGL  = 2'd3
  } act_e;

  // Per-output action set: LSB field is the duty match action.
  typedef struct packed {
    act_e on_sw;
    act_e on_per;
    act_e on_cmp;
  } out_act_t;

  localparam logic [2:0] ADDR_MODE = 3'd0;
  localparam logic [2:0] ADDR_CMPA = 3'd1;
  localparam logic [2:0] ADDR_CMPB = 3'd2;
  localparam logic [2:0] ADDR_PER  = 3'd3;
  localparam logic [2:0] ADDR_CTRL = 3'd4;

  localparam int CTRL_EN  = 0;
  localparam int CTRL_DIS = 1;
  localparam int CTRL_SW  = 2;

  localparam int MODE_W   = 15;
  localparam int SEL_W    = 3;
  localparam int ACT_W    = 6;

  function automatic logic act_apply(act_e a, logic cur);
    case (a)
      ACT_SET: act_apply = 1'b1;
      ACT_CLR: act_apply = 1'b0;
      ACT_TGL: act_apply = ~cur;
      default: act_apply = cur;
    endcase
  endfunction
endpackage

// File: rtl/wtc_prescaler.sv
module wtc_prescaler #(
  parameter int PRE_W   = 7,
  parameter int NUM_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [2:0] sel,
  input  logic       slow_tick,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  // Divider code k divides by 2^(2k+1).
  always_comb begin
    for (int i = 0; i < PRE_W; i++) begin
      mask[i] = (i <= 2 * int'(sel));
    end
  end

  always_comb begin
    if (!run)
      tick = 1'b0;
    else if (int'(sel) >= NUM_DIV)
      tick = slow_tick;
    else
      tick = ((pre_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pre_q <= '0;
    else if (restart)
      pre_q <= '0;
    else if (run)
      pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wtc_counter.sv
module wtc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] per_act,
  output logic [CNT_W-1:0] count,
  output logic             ev_per
);
  assign ev_per = tick && (count == per_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (restart || ev_per)
      count <= '0;
    else if (tick)
      count <= count + 1'b1;
  end
endmodule

// File: rtl/wtc_out_action.sv
module wtc_out_action
  import wtc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  out_act_t act,
  input  logic     ev_cmp,
  input  logic     ev_per,
  input  logic     sw,
  output logic     lvl
);
  logic lvl_nxt;

  // Trigger over period match over duty match; a period event whose
  // action is none lets the duty action through.
  always_comb begin
    if (sw)
      lvl_nxt = act_apply(act.on_sw, lvl);
    else if (ev_per && act.on_per != ACT_NONE)
      lvl_nxt = act_apply(act.on_per, lvl);
    else if (ev_cmp)
      lvl_nxt = act_apply(act.on_cmp, lvl);
    else
      lvl_nxt = lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lvl <= 1'b0;
    else
      lvl <= lvl_nxt;
  end
endmodule

// File: rtl/wtc_channel.sv
module wtc_channel
  import wtc_pkg::*;
#(
  parameter int CNT_W   = 16,  // at least MODE_W so the mode word fits
  parameter int PRE_W   = 7,
  parameter int NUM_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  input  logic             slow_tick,
  output logic             out_a,
  output logic             out_b,
  output logic [CNT_W-1:0] count
);
  localparam int NOUT = 2;

  logic [MODE_W-1:0] mode_q;
  logic [CNT_W-1:0]  per_sh, per_act;
  logic [CNT_W-1:0]  cmp_sh  [NOUT];
  logic [CNT_W-1:0]  cmp_act [NOUT];
  logic [NOUT-1:0]   ev_cmp;
  logic [NOUT-1:0]   lvl;
  logic              running;
  logic              tick, ev_per;
  logic              ctrl_wr, sw_cmd, en_cmd, dis_cmd, load;

  assign ctrl_wr = cfg_we && (cfg_addr == ADDR_CTRL);
  assign sw_cmd  = ctrl_wr && cfg_wdata[CTRL_SW];
  assign en_cmd  = ctrl_wr && cfg_wdata[CTRL_EN];
  assign dis_cmd = ctrl_wr && cfg_wdata[CTRL_DIS];
  assign load    = sw_cmd || ev_per;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      running <= 1'b0;
    else if (dis_cmd)
      running <= 1'b0;
    else if (en_cmd)
      running <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mode_q <= '0;
    else if (cfg_we && cfg_addr == ADDR_MODE)
      mode_q <= cfg_wdata[MODE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_sh  <= '0;
      per_act <= '0;
    end else begin
      if (cfg_we && cfg_addr == ADDR_PER)
        per_sh <= cfg_wdata;
      if (load)
        per_act <= per_sh;
    end
  end

  wtc_prescaler #(.PRE_W(PRE_W), .NUM_DIV(NUM_DIV)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (running),
    .restart  (sw_cmd),
    .sel      (mode_q[SEL_W-1:0]),
    .slow_tick(slow_tick),
    .tick     (tick)
  );

  wtc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .restart(sw_cmd),
    .per_act(per_act),
    .count  (count),
    .ev_per (ev_per)
  );

  for (genvar g = 0; g < NOUT; g++) begin : g_out
    localparam logic [2:0] MY_ADDR = ADDR_CMPA + 3'(g);
    localparam int         ACT_LO  = SEL_W + g * ACT_W;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_sh[g]  <= '0;
        cmp_act[g] <= '0;
      end else begin
        if (cfg_we && cfg_addr == MY_ADDR)
          cmp_sh[g] <= cfg_wdata;
        if (load)
          cmp_act[g] <= cmp_sh[g];
      end
    end

    assign ev_cmp[g] = tick && (count == cmp_act[g]);

    wtc_out_action u_act (
      .clk   (clk),
      .rst_n (rst_n),
      .act   (out_act_t'(mode_q[ACT_LO +: ACT_W])),
      .ev_cmp(ev_cmp[g]),
      .ev_per(ev_per),
      .sw    (sw_cmd),
      .lvl   (lvl[g])
    );
  end

  assign out_a = lvl[0];
  assign out_b = lvl[1];
endmodule

// File: rtl/wtc_channel_chk.sv
module wtc_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [2:0]       cfg_addr,
  input logic [CNT_W-1:0] cfg_wdata,
  input logic [CNT_W-1:0] count,
  input logic             out_a,
  input logic             out_b,
  input logic [CNT_W-1:0] per_act,
  input logic             running,
  input logic             ev_per,
  input logic [1:0]       ev_cmp,
  input logic [14:0]      mode_q
);
  logic sw;
  assign sw = cfg_we && (cfg_addr == 3'd4) && cfg_wdata[2];

  // R2: the counter never exceeds the active period
  a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    count <= per_act);

  // R12: trigger zeroes the counter
  a_r12_sw_restart: assert property (@(posedge clk) disable iff (!rst_n)
    sw |=> (count == '0));

  // R9: stopped channel holds counter and outputs
  a_r9_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !sw) |=> ($stable(count) && $stable(out_a) && $stable(out_b)));

  // R7: period action beats duty action on the same tick
  a_r7_period_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw && ev_per && ev_cmp[0] && mode_q[6:5] == 2'd1 && mode_q[4:3] == 2'd2) |=> out_a);

  // R8: trigger with set action drives output A high
  a_r8_sw_level: assert property (@(posedge clk) disable iff (!rst_n)
    (sw && mode_q[8:7] == 2'd1) |=> out_a);
endmodule

bind wtc_channel wtc_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_we   (cfg_we),
  .cfg_addr (cfg_addr),
  .cfg_wdata(cfg_wdata),
  .count    (count),
  .out_a    (out_a),
  .out_b    (out_b),
  .per_act  (per_act),
  .running  (running),
  .ev_per   (ev_per),
  .ev_cmp   (ev_cmp),
  .mode_q   (mode_q)
);

// File: tb/tb_wtc_channel.sv
`timescale 1ns/1ps
module tb_wtc_channel;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic [2:0]   cfg_addr = '0;
  logic [W-1:0] cfg_wdata = '0;
  logic         slow_tick = 1'b0;
  logic         out_a, out_b;
  logic [W-1:0] count;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  wtc_channel dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .slow_tick(slow_tick),
    .out_a(out_a), .out_b(out_b), .count(count)
  );

  localparam logic [1:0] N = 2'd0, S = 2'd1, C = 2'd2, T = 2'd3;

  function automatic logic [W-1:0] mk_mode(logic [2:0] sel,
      logic [1:0] ac, logic [1:0] ap, logic [1:0] as,
      logic [1:0] bc, logic [1:0] bp, logic [1:0] bs);
    mk_mode = {1'b0, bs, bp, bc, as, ap, ac, sel};
  endfunction

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [W-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic high_count(int cycles, output int ha, output int hb);
    ha = 0; hb = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      ha += int'(out_a); hb += int'(out_b);
    end
  endtask

  task automatic t_reset();
    chk("R1 out_a", int'(out_a), 0);
    chk("R1 out_b", int'(out_b), 0);
    chk("R1 count", int'(count), 0);
  endtask

  task automatic t_pwm();
    int ha, hb, ra, rb, mx;
    logic pa, pb;
    wr(3'd0, mk_mode(3'd0, C, S, S, S, C, C));
    wr(3'd3, 16'd9); wr(3'd1, 16'd3); wr(3'd2, 16'd6);
    wr(3'd4, 16'h5);
    repeat (40) @(negedge clk);
    high_count(20, ha, hb);
    chk("R3 A high cycles", ha, 8);
    chk("R4 B high cycles", hb, 6);
    pa = out_a; pb = out_b; ra = 0; rb = 0; mx = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (out_a && !pa) ra++;
      if (out_b && !pb) rb++;
      pa = out_a; pb = out_b;
      if (int'(count) > mx) mx = int'(count);
    end
    chk("R5 A periods", ra, 2);
    chk("R5 B periods", rb, 2);
    chk("R2 max count", mx, 9);
  endtask

  task automatic t_toggle();
    int ha, hb;
    wr(3'd0, mk_mode(3'd0, N, T, C, N, N, S));
    wr(3'd3, 16'd4);
    wr(3'd4, 16'h5);
    repeat (3) @(negedge clk);
    high_count(40, ha, hb);
    chk("R6 toggle A", ha, 20);
    chk("R6 none B", hb, 40);
  endtask

  task automatic t_priority();
    int ha, hb;
    wr(3'd0, mk_mode(3'd0, C, S, C, N, N, N));
    wr(3'd3, 16'd5); wr(3'd1, 16'd5);
    wr(3'd4, 16'h5);
    repeat (30) @(negedge clk);
    high_count(24, ha, hb);
    chk("R7 period over duty", ha, 24);
  endtask

  task automatic t_static();
    int ha, hb;
    wr(3'd0, mk_mode(3'd0, N, N, S, N, N, C));
    wr(3'd3, 16'd3);
    wr(3'd4, 16'h5);
    high_count(30, ha, hb);
    chk("R8 100pct A", ha, 30);
    chk("R8 0pct B", hb, 0);
    wr(3'd0, mk_mode(3'd0, N, N, C, N, N, S));
    wr(3'd4, 16'h4);
    chk("R8 A after trigger", int'(out_a), 0);
    chk("R8 B after trigger", int'(out_b), 1);
  endtask

  task automatic t_restart();
    int guard = 0;
    wr(3'd3, 16'd9);
    wr(3'd4, 16'h5);
    while (count < 16'd4 && guard < 100) begin @(negedge clk); guard++; end
    wr(3'd4, 16'h4);
    chk("R12 counter zeroed", int'(count), 0);
  endtask

  task automatic t_hold();
    logic [W-1:0] c0;
    logic a0, b0;
    int moved = 0;
    wr(3'd0, mk_mode(3'd0, C, S, S, S, C, C));
    wr(3'd3, 16'd9); wr(3'd1, 16'd3); wr(3'd2, 16'd6);
    wr(3'd4, 16'h5);
    repeat (13) @(negedge clk);
    wr(3'd4, 16'h3);
    c0 = count; a0 = out_a; b0 = out_b;
    repeat (30) @(negedge clk);
    chk("R9 count held", int'(count), int'(c0));
    chk("R9 A held", int'(out_a), int'(a0));
    chk("R9 B held", int'(out_b), int'(b0));
    wr(3'd4, 16'h1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (count != c0) moved = 1;
    end
    chk("R9 restart resumes", moved, 1);
  endtask

  task automatic t_stop_trig();
    wr(3'd0, mk_mode(3'd0, C, S, S, S, C, C));
    wr(3'd4, 16'h5);
    repeat (7) @(negedge clk);
    wr(3'd4, 16'h6);
    repeat (25) @(negedge clk);
    chk("R13 A forced", int'(out_a), 1);
    chk("R13 B forced", int'(out_b), 0);
    chk("R13 count", int'(count), 0);
  endtask

  task automatic t_shadow();
    int mx, guard;
    logic [W-1:0] pv;
    wr(3'd0, mk_mode(3'd0, C, S, S, S, C, C));
    wr(3'd3, 16'd9); wr(3'd4, 16'h5);
    guard = 0;
    while (count != 16'd2 && guard < 100) begin @(negedge clk); guard++; end
    wr(3'd3, 16'd30);
    for (int pass = 0; pass < 2; pass++) begin
      mx = 0; pv = count; guard = 0;
      while (guard < 400) begin
        @(negedge clk); guard++;
        if (count == 0 && pv != 0) break;
        if (int'(count) > mx) mx = int'(count);
        pv = count;
      end
      chk(pass == 0 ? "R10 old period kept" : "R10 new period used",
          mx, pass == 0 ? 9 : 30);
    end
  endtask

  task automatic measure_step(output int gap);
    logic [W-1:0] c;
    c = count; gap = 0;
    while (count == c && gap < 400) begin @(negedge clk); gap++; end
    c = count; gap = 0;
    while (count == c && gap < 400) begin @(negedge clk); gap++; end
  endtask

  task automatic t_prescale();
    int gap;
    wr(3'd3, 16'd1000);
    wr(3'd0, mk_mode(3'd1, N, N, N, N, N, N));
    wr(3'd4, 16'h5);
    measure_step(gap);
    chk("R11 divide by 8", gap, 8);
    wr(3'd0, mk_mode(3'd3, N, N, N, N, N, N));
    wr(3'd4, 16'h5);
    measure_step(gap);
    chk("R11 divide by 128", gap, 128);
    wr(3'd0, mk_mode(3'd4, N, N, N, N, N, N));
    wr(3'd4, 16'h5);
    repeat (20) @(negedge clk);
    chk("R11 slow idle", int'(count), 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); slow_tick = 1'b1;
      @(negedge clk); slow_tick = 1'b0;
      repeat (3) @(negedge clk);
    end
    chk("R11 slow ticks", int'(count), 5);
    wr(3'd4, 16'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pwm();
    t_toggle();
    t_priority();
    t_static();
    t_restart();
    t_hold();
    t_stop_trig();
    t_shadow();
    t_prescale();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule